// File: doc/BRIEF.md
# Stochastic Synaptic Fan-Out Expander

This block sits on a spike-event bus and turns each arriving event, which names only the neuron that fired, into the set of weighted events that neuron's synapses deliver. The time of a spike is carried by when it arrives, so the block keeps no timestamps. Wiring is held in an on-chip table. Each source has a base pointer into a list of synapse records stored back to back, and a flag on the final record closes that source's list.

Each synapse record names a destination neuron and three release parameters: a repeat count, a release probability and an amplitude. For every synapse the block considers the event once per unit of the repeat count. A pseudo-random coin keeps or drops each candidate according to the probability. A candidate that is kept leaves on the output stream tagged with the destination and the amplitude. Input and output are valid/ready streams. A host configuration port rewrites base pointers or records while the block runs. A write that arrives during a fan-out is held off until that fan-out is done, so no fan-out sees a half-changed list.

Top module: `syn_fanout_expander`

## Requirements
- R1: An accepted event on source `s` walks the records from the base pointer of `s` in ascending address order. The walk stops after the record whose end flag is 1, and released events leave in walk order carrying the record's destination on `out_tgt`.
- R2: A record with repeat count n yields exactly n release candidates. A record with n = 0 yields no output, and the walk still continues to the next record, or ends if that record's end flag is set.
- R3: The coin is a 16-bit Fibonacci LFSR that shifts left. The new bit 0 is the XOR of bits 15, 13, 12 and 10. The LFSR holds 0xACE1 after reset and advances exactly once per candidate. A candidate is released when the LFSR's low byte, taken before that advance, is less than p, or when p is 255. A p of 0 never releases.
- R4: Every released event carries the record's amplitude q on `out_amp`.
- R5: `in_ready` is 1 only while no fan-out is in progress. It is 0 from the cycle after an event is accepted until the walk has finished.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_tgt` and `out_amp` hold their values into the next cycle.
- R7: A configuration write happens on a cycle where both `cfg_valid` and `cfg_ready` are 1. `cfg_ready` is 0 during a walk, and the walk in progress uses the table as it was when it started. With `cfg_is_base` = 0, `cfg_data` is a record written at address `cfg_addr`, laid out as {dest[31:20], n[19:17], p[16:9], q[8:1], end[0]}. With `cfg_is_base` = 1, `cfg_data[5:0]` becomes the base pointer of source `cfg_addr[3:0]`.
- R8: When the first candidate of the first record is released, `out_valid` rises after the second clock edge that follows acceptance of the event.
- R9: After reset, `in_ready` and `cfg_ready` are 1, `out_valid` is 0, and every base pointer and record is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input spike event valid |
| in_ready | output | 1 | Block can take an input event |
| in_src | input | SRC_W (4) | Source neuron address |
| out_valid | output | 1 | Output synaptic event valid |
| out_ready | input | 1 | Downstream takes the output event |
| out_tgt | output | TGT_W (12) | Destination neuron address |
| out_amp | output | AMP_W (8) | Amplitude of the released event |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Configuration write can be taken |
| cfg_is_base | input | 1 | 1 writes a base pointer, 0 writes a record |
| cfg_addr | input | CFG_AW (6) | Record address or source index |
| cfg_data | input | ENTRY_W (32) | Record contents or base pointer |

## Verification
After an event is accepted, `in_ready` falls in the cycle right after the accepting edge. The first released event appears after the second edge, and each later candidate needs one edge for its coin toss plus one for its handshake. The bench drives inputs on the falling edge and samples one time step later. It checks the exact cycle of the first output for a record that always releases. For every other event it compares the ordered list of handshaken outputs against a list its own LFSR model predicts, so stall patterns on `out_ready` do not move the expected values. The hold rule and the deferred write are checked in the cycles where the stall or the pending write is present.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int LFSR_W = 16;
  localparam int PROB_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_TOSS  = 2'd2,
    W_SEND  = 2'd3
  } walk_state_t;

  // one step of the left-shifting Fibonacci register, taps 15,13,12,10
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // coin toss: full-scale probability always releases
  function automatic logic coin_release(input logic [LFSR_W-1:0] s,
                                        input logic [PROB_W-1:0] p);
    return (p == {PROB_W{1'b1}}) || (s[PROB_W-1:0] < p);
  endfunction
endpackage

// File: rtl/syn_lfsr.sv
module syn_lfsr
  import syn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= LFSR_SEED;
    else if (step) state <= lfsr_step(state);
  end
endmodule

// File: rtl/syn_route_table.sv
module syn_route_table #(
  parameter int SRC_W   = 4,
  parameter int PTR_W   = 6,
  parameter int ENTRY_W = 32,
  parameter int CFG_AW  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_is_base,
  input  logic [CFG_AW-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [SRC_W-1:0]   rd_src,
  input  logic [PTR_W-1:0]   rd_ptr,
  output logic [PTR_W-1:0]   base_out,
  output logic [ENTRY_W-1:0] entry_out
);
  localparam int NSRC  = 1 << SRC_W;
  localparam int DEPTH = 1 << PTR_W;

  logic [PTR_W-1:0]   base_mem [NSRC];
  logic [ENTRY_W-1:0] ent_mem  [DEPTH];

  for (genvar gs = 0; gs < NSRC; gs++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base_mem[gs] <= '0;
      else if (wr_en && wr_is_base && (wr_addr[SRC_W-1:0] == SRC_W'(gs)))
        base_mem[gs] <= wr_data[PTR_W-1:0];
    end
  end

  for (genvar ge = 0; ge < DEPTH; ge++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_mem[ge] <= '0;
      else if (wr_en && !wr_is_base && (wr_addr[PTR_W-1:0] == PTR_W'(ge)))
        ent_mem[ge] <= wr_data;
    end
  end

  assign base_out  = base_mem[rd_src];
  assign entry_out = ent_mem[rd_ptr];
endmodule

// File: rtl/syn_walker.sv
module syn_walker
  import syn_pkg::*;
#(
  parameter int SRC_W  = 4,
  parameter int PTR_W  = 6,
  parameter int TGT_W  = 12,
  parameter int MULT_W = 3,
  parameter int AMP_W  = 8,
  localparam int ENTRY_W = TGT_W + MULT_W + PROB_W + AMP_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               idle,
  input  logic [PTR_W-1:0]   base_ptr,
  output logic [PTR_W-1:0]   rd_ptr,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [LFSR_W-1:0]  lfsr,
  output logic               cand_fire,
  output logic [PROB_W-1:0]  cand_prob,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [TGT_W-1:0]   out_tgt,
  output logic [AMP_W-1:0]   out_amp
);
  localparam int LAST_B = 0;
  localparam int AMP_L  = 1;
  localparam int PROB_L = AMP_L + AMP_W;
  localparam int MULT_L = PROB_L + PROB_W;
  localparam int TGT_L  = MULT_L + MULT_W;

  walk_state_t        state;
  logic [PTR_W-1:0]   ptr;
  logic [MULT_W-1:0]  rep;
  logic [TGT_W-1:0]   cur_tgt;
  logic [PROB_W-1:0]  cur_p;
  logic [AMP_W-1:0]   cur_q;
  logic               cur_last;

  logic [TGT_W-1:0]   e_tgt;
  logic [MULT_W-1:0]  e_n;
  logic [PROB_W-1:0]  e_p;
  logic [AMP_W-1:0]   e_q;
  logic               e_last;
  logic               released;

  assign e_tgt  = entry[TGT_L +: TGT_W];
  assign e_n    = entry[MULT_L +: MULT_W];
  assign e_p    = entry[PROB_L +: PROB_W];
  assign e_q    = entry[AMP_L +: AMP_W];
  assign e_last = entry[LAST_B];

  assign idle      = (state == W_IDLE);
  assign rd_ptr    = ptr;
  assign cand_fire = (state == W_TOSS);
  assign cand_prob = cur_p;
  assign released  = coin_release(lfsr, cur_p);
  assign out_valid = (state == W_SEND);
  assign out_tgt   = cur_tgt;
  assign out_amp   = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= W_IDLE;
      ptr      <= '0;
      rep      <= '0;
      cur_tgt  <= '0;
      cur_p    <= '0;
      cur_q    <= '0;
      cur_last <= 1'b0;
    end else begin
      unique case (state)
        W_IDLE: begin
          if (in_valid) begin
            ptr   <= base_ptr;
            state <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (e_n == '0) begin
            if (e_last) state <= W_IDLE;
            else        ptr   <= ptr + PTR_W'(1);
          end else begin
            cur_tgt  <= e_tgt;
            cur_p    <= e_p;
            cur_q    <= e_q;
            cur_last <= e_last;
            rep      <= e_n;
            state    <= W_TOSS;
          end
        end
        W_TOSS: begin
          rep <= rep - MULT_W'(1);
          if (released) begin
            state <= W_SEND;
          end else if (rep == MULT_W'(1)) begin
            if (cur_last) state <= W_IDLE;
            else begin
              ptr   <= ptr + PTR_W'(1);
              state <= W_FETCH;
            end
          end
        end
        W_SEND: begin
          if (out_ready) begin
            if (rep != '0)    state <= W_TOSS;
            else if (cur_last) state <= W_IDLE;
            else begin
              ptr   <= ptr + PTR_W'(1);
              state <= W_FETCH;
            end
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/syn_fanout_expander.sv
module syn_fanout_expander
  import syn_pkg::*;
#(
  parameter int SRC_W  = 4,
  parameter int TGT_W  = 12,
  parameter int MULT_W = 3,
  parameter int AMP_W  = 8,
  parameter int DEPTH  = 64,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CFG_AW  = (PTR_W > SRC_W) ? PTR_W : SRC_W,
  localparam int ENTRY_W = TGT_W + MULT_W + PROB_W + AMP_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SRC_W-1:0]   in_src,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [TGT_W-1:0]   out_tgt,
  output logic [AMP_W-1:0]   out_amp,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic               cfg_is_base,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_data
);
  logic               walk_idle;
  logic [PTR_W-1:0]   base_ptr;
  logic [PTR_W-1:0]   rd_ptr;
  logic [ENTRY_W-1:0] entry;
  logic [LFSR_W-1:0]  lfsr_state;
  logic               cand_fire;
  logic [PROB_W-1:0]  cand_prob;
  logic               cfg_take;

  assign in_ready  = walk_idle;
  assign cfg_ready = walk_idle;
  assign cfg_take  = cfg_valid && cfg_ready;

  syn_route_table #(
    .SRC_W(SRC_W), .PTR_W(PTR_W), .ENTRY_W(ENTRY_W), .CFG_AW(CFG_AW)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_take), .wr_is_base(cfg_is_base), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .rd_src(in_src), .rd_ptr(rd_ptr), .base_out(base_ptr), .entry_out(entry)
  );

  syn_lfsr u_coin (
    .clk(clk), .rst_n(rst_n), .step(cand_fire), .state(lfsr_state)
  );

  syn_walker #(
    .SRC_W(SRC_W), .PTR_W(PTR_W), .TGT_W(TGT_W), .MULT_W(MULT_W), .AMP_W(AMP_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .idle(walk_idle),
    .base_ptr(base_ptr), .rd_ptr(rd_ptr), .entry(entry), .lfsr(lfsr_state),
    .cand_fire(cand_fire), .cand_prob(cand_prob),
    .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt), .out_amp(out_amp)
  );
endmodule

// File: rtl/syn_fanout_checker.sv
module syn_fanout_checker #(
  parameter int TGT_W = 12,
  parameter int AMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TGT_W-1:0] out_tgt,
  input logic [AMP_W-1:0] out_amp,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic             cand_fire,
  input logic [7:0]       cand_prob,
  input logic [15:0]      lfsr_state
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tgt) && $stable(out_amp));

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_no_input_while_sending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_cfg_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |-> !out_valid);

  assert_zero_prob_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_fire && (cand_prob == 8'h00) |=> !out_valid);

  assert_full_prob_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_fire && (cand_prob == 8'hFF) |=> out_valid);

  assert_lfsr_alive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != 16'h0000);
endmodule

bind syn_fanout_expander syn_fanout_checker #(.TGT_W(TGT_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt), .out_amp(out_amp),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cand_fire(cand_fire), .cand_prob(cand_prob), .lfsr_state(lfsr_state)
);

// File: tb/tb_syn_fanout_expander.sv
`timescale 1ns/1ps
module tb_syn_fanout_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_tgt;
  logic [7:0]  out_amp;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic        cfg_is_base = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;

  always #5 clk = ~clk;

  syn_fanout_expander dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt), .out_amp(out_amp),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_is_base(cfg_is_base),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int checks = 0;
  int fails  = 0;

  // bench copy of the table it programmed
  logic [5:0]  m_base [16];
  logic [11:0] m_tgt  [64];
  logic [2:0]  m_n    [64];
  logic [7:0]  m_p    [64];
  logic [7:0]  m_q    [64];
  logic        m_last [64];
  logic [15:0] m_lfsr = 16'hACE1;

  logic [11:0] exp_tgt [256];
  logic [7:0]  exp_amp [256];
  int          exp_cnt;

  // {stall, src}
  localparam logic [4:0] VEC [8] = '{5'h00, 5'h11, 5'h02, 5'h13, 5'h01, 5'h10, 5'h03, 5'h11};

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] s);
    logic fb;
    fb = ^(s & 16'hB400);
    return (s << 1) | {15'd0, fb};
  endfunction

  function automatic bit model_keep(input logic [15:0] s, input logic [7:0] p);
    if (p == 8'd255) return 1'b1;
    return (int'(s) % 256) < int'(p);
  endfunction

  task automatic build_expect(input int src);
    int ptr;
    ptr = m_base[src];
    exp_cnt = 0;
    for (int guard = 0; guard < 64; guard++) begin
      for (int k = 0; k < int'(m_n[ptr]); k++) begin
        if (model_keep(m_lfsr, m_p[ptr])) begin
          exp_tgt[exp_cnt] = m_tgt[ptr];
          exp_amp[exp_cnt] = m_q[ptr];
          exp_cnt++;
        end
        m_lfsr = model_next(m_lfsr);
      end
      if (m_last[ptr]) break;
      ptr = (ptr + 1) % 64;
    end
  endtask

  task automatic write_entry(input int idx, input logic [11:0] t, input logic [2:0] n,
                             input logic [7:0] p, input logic [7:0] q, input bit last);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_is_base = 1'b0; cfg_addr = 6'(idx);
    cfg_data = {t, n, p, q, last};
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    m_tgt[idx] = t; m_n[idx] = n; m_p[idx] = p; m_q[idx] = q; m_last[idx] = last;
  endtask

  task automatic write_base(input int src, input int ptr);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_is_base = 1'b1; cfg_addr = 6'(src); cfg_data = 32'(ptr);
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    m_base[src] = 6'(ptr);
  endtask

  task automatic run_event(input int src, input bit stall, input bit lat_check);
    int got;
    bit hold_pend;
    logic [11:0] h_tgt;
    logic [7:0]  h_amp;
    build_expect(src);
    @(negedge clk);
    in_valid = 1'b1; in_src = 4'(src); out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(in_ready == 1'b0, "R5 in_ready after accept", int'(in_ready), 0);
    got = 0; hold_pend = 1'b0; h_tgt = '0; h_amp = '0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      out_ready = stall ? ((cyc % 3) == 2) : 1'b1;
      #1;
      if (lat_check && cyc <= 2)
        check(out_valid == (cyc == 2), "R8 first output latency", int'(out_valid), int'(cyc == 2));
      if (hold_pend)
        check(out_valid && out_tgt == h_tgt && out_amp == h_amp, "R6 hold under stall",
              int'({out_valid, out_tgt, out_amp}), int'({1'b1, h_tgt, h_amp}));
      if (!out_valid && in_ready) break;
      if (out_valid && out_ready) begin
        if (got < exp_cnt) begin
          check(out_tgt == exp_tgt[got], "R1 target order", int'(out_tgt), int'(exp_tgt[got]));
          check(out_amp == exp_amp[got], "R4 amplitude", int'(out_amp), int'(exp_amp[got]));
        end
        got++;
      end
      hold_pend = out_valid && !out_ready;
      h_tgt = out_tgt; h_amp = out_amp;
      @(negedge clk);
    end
    check(got == exp_cnt, "R2 R3 released count", got, exp_cnt);
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_base[i] = '0;
    for (int i = 0; i < 64; i++) begin
      m_tgt[i] = '0; m_n[i] = '0; m_p[i] = '0; m_q[i] = '0; m_last[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check(in_ready == 1'b1,  "R9 in_ready after reset",  int'(in_ready), 1);
    check(cfg_ready == 1'b1, "R9 cfg_ready after reset", int'(cfg_ready), 1);
    check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);

    // R7 program the table
    write_base(0, 0); write_base(1, 4); write_base(2, 8); write_base(3, 10);
    write_entry(0,  12'h101, 3'd2, 8'd255, 8'h11, 1'b0);
    write_entry(1,  12'h202, 3'd0, 8'd255, 8'h22, 1'b0);
    write_entry(2,  12'h303, 3'd1, 8'd255, 8'h33, 1'b1);
    write_entry(4,  12'h044, 3'd7, 8'd128, 8'h44, 1'b0);
    write_entry(5,  12'h055, 3'd3, 8'd0,   8'h55, 1'b1);
    write_entry(8,  12'h088, 3'd0, 8'd255, 8'h88, 1'b1);
    write_entry(10, 12'h0AA, 3'd4, 8'd255, 8'hAA, 1'b1);

    // R8 latency on an always-release record
    run_event(3, 1'b0, 1'b1);

    // vector table walk
    foreach (VEC[i]) run_event(int'(VEC[i][3:0]), VEC[i][4], 1'b0);

    // R2 n=0-only list gives nothing; source 0 skips its n=0 middle record
    build_expect(2);
    check(exp_cnt == 0, "R2 model n=0 list empty", exp_cnt, 0);
    run_event(2, 1'b0, 1'b0);

    // R7 write during a walk waits and does not disturb it
    fork
      run_event(1, 1'b1, 1'b0);
      begin
        repeat (4) @(negedge clk);
        cfg_valid = 1'b1; cfg_is_base = 1'b0; cfg_addr = 6'd4;
        cfg_data = {12'h0A4, 3'd2, 8'd255, 8'h5A, 1'b0};
        #1;
        check(cfg_ready == 1'b0, "R7 cfg_ready low during walk", int'(cfg_ready), 0);
        for (int w = 0; w < 4000; w++) begin
          if (cfg_ready) break;
          @(negedge clk);
          #1;
        end
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        m_tgt[4] = 12'h0A4; m_n[4] = 3'd2; m_p[4] = 8'd255; m_q[4] = 8'h5A; m_last[4] = 1'b0;
      end
    join
    // R7 rewritten record now used
    run_event(1, 1'b0, 1'b0);
    run_event(0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule